// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine moves received frames from a byte stream into host memory. Host software keeps a circular chain of four-word descriptors, and each one points at a buffer. The engine walks that chain. For each descriptor it reads the command/status word, the link word and the buffer word. It then writes the frame into the buffer one byte at a time. Last, it writes a completion status word back into the descriptor and moves on by following the link. All memory traffic uses a single word-wide request/acknowledge port.

Software sets the start address of the ring while the engine is idle. It controls the engine through a small command register. One code starts reception, one stops it cleanly, and two reset codes clear the engine. A frame larger than one buffer is split over several descriptors that follow each other. If the engine reaches a descriptor that software has not yet handed back, it stops and waits for a new start command.

Top module: `rx_ring_engine`

## Requirements
- R1: After rst_ni is released, idle_o is 1, s_ready_o is 0, ring_ptr_o is 0 and cmd_rdata_o is 0.
- R2: A write to the ring pointer takes effect only while idle_o is 1, and bits 2:0 are forced to zero. A write made while the engine runs leaves ring_ptr_o unchanged.
- R3: Command value 0x004 (receive on) starts descriptor processing at ring_ptr_o. The engine reads the command/status word at +8, the link at +0 and the buffer address at +4. The word at +12 is never read or written.
- R4: Frame bytes are stored in arrival order at buffer address plus offset. Each byte is a single-lane write whose byte enable bit equals address bits 1:0.
- R5: The completion status word has bit 31 set and holds the byte count of that descriptor in bits 11:0. For the last piece of a frame, bit 19 is set if the error flag came with the end byte. Bit 27 is set when neither the error nor the overlong condition holds.
- R6: When a frame outgrows the buffer size read from bits 11:0, the filled descriptor completes with status 0xC0000000 plus the size. Bit 27 is clear in that status, and the frame continues in the next descriptor.
- R7: A frame whose total length exceeds 1518 bytes completes with bit 22 set and bit 27 clear.
- R8: After each completion the engine moves to the address in that descriptor's link word, so the ring wraps from its last descriptor back to its first.
- R9: If the fetched command/status word already has bit 31 set, the engine goes idle. ring_ptr_o then holds that descriptor's address, the descriptor is left unmodified, and only a new receive-on command restarts the engine.
- R10: Command value 0x008 (receive off) issued mid-frame lets that frame complete normally before idle_o rises.
- R11: Command value 0x100 reads back nonzero until it has been applied, then reads zero. It leaves the engine idle with ring_ptr_o at 0. Value 0x020 also idles the engine and reads back the same way, but it keeps ring_ptr_o.
- R12: Bytes offered without the start flag while no frame is open are consumed and discarded.
- R13: A memory request keeps its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 9 | Command code |
| cmd_rdata_o | output | 9 | Command readback; reset bits stay set while pending |
| ptr_we_i | input | 1 | Ring pointer write strobe |
| ptr_wdata_i | input | 32 | Ring pointer value |
| ring_ptr_o | output | 32 | Address of the current descriptor |
| idle_o | output | 1 | Engine is stopped or parked on a host-owned descriptor |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Stream byte accepted on this edge |
| s_data_i | input | 8 | Stream byte |
| s_sof_i | input | 1 | First byte of a frame |
| s_eof_i | input | 1 | Last byte of a frame |
| s_err_i | input | 1 | Frame error, sampled with the last byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request done; read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The hardest case to reach is the engine parking on a descriptor that the host still owns. It only happens when the prefetch after a completion lands on a descriptor the host has not handed back. The bench sets that up by marking the descriptor after the current one as owned, with a marker value, before sending a short frame. It then checks that idle_o is high, that the pointer sits on that descriptor and that the marker is untouched, and only then hands the descriptor back and issues receive-on. Frames that span up to three 64-byte buffers on a four-entry ring push the continuation path across the wrap point.

// File: rtl/rx_ring_pkg.sv
`timescale 1ns/1ps
package rx_ring_pkg;
  localparam int unsigned CMD_W = 9;
  localparam logic [CMD_W-1:0] CMD_CHIP_RST = 9'h100;
  localparam logic [CMD_W-1:0] CMD_RX_RST   = 9'h020;
  localparam logic [CMD_W-1:0] CMD_RX_OFF   = 9'h008;
  localparam logic [CMD_W-1:0] CMD_RX_ON    = 9'h004;

  localparam int unsigned ST_OWN  = 31;
  localparam int unsigned ST_MORE = 30;
  localparam int unsigned ST_OK   = 27;
  localparam int unsigned ST_LONG = 22;
  localparam int unsigned ST_CRC  = 19;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_STS, S_RD_LINK, S_RD_BUF, S_RECV, S_WR_BYTE, S_WB_STS
  } walk_state_e;
endpackage

// File: rtl/rx_ring_cmd.sv
`timescale 1ns/1ps
module rx_ring_cmd
  import rx_ring_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             bus_free_i,
  output logic [CMD_W-1:0] cmd_rdata_o,
  output logic             flush_o,
  output logic             clr_ptr_o,
  output logic             go_o,
  output logic             halt_o
);
  logic chip_q, rxr_q, pend, wr_rst;
  logic unused_bits;

  assign pend   = chip_q | rxr_q;
  assign wr_rst = |(cmd_wdata_i & (CMD_CHIP_RST | CMD_RX_RST));
  assign unused_bits = ^{cmd_wdata_i[7:6], cmd_wdata_i[4], cmd_wdata_i[1:0]};

  // reset waits for any open memory transaction to close
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_q <= 1'b0;
      rxr_q  <= 1'b0;
    end else if (pend && bus_free_i) begin
      chip_q <= 1'b0;
      rxr_q  <= 1'b0;
    end else if (cmd_we_i) begin
      chip_q <= chip_q | (|(cmd_wdata_i & CMD_CHIP_RST));
      rxr_q  <= rxr_q  | (|(cmd_wdata_i & CMD_RX_RST));
    end
  end

  assign flush_o   = pend && bus_free_i;
  assign clr_ptr_o = chip_q && bus_free_i;
  assign halt_o    = cmd_we_i && !pend && !wr_rst && (|(cmd_wdata_i & CMD_RX_OFF));
  assign go_o      = cmd_we_i && !pend && !wr_rst && (|(cmd_wdata_i & CMD_RX_ON))
                     && !(|(cmd_wdata_i & CMD_RX_OFF));
  assign cmd_rdata_o = (chip_q ? CMD_CHIP_RST : '0) | (rxr_q ? CMD_RX_RST : '0);
endmodule

// File: rtl/rx_ring_stsword.sv
`timescale 1ns/1ps
module rx_ring_stsword
  import rx_ring_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             more_i,
  input  logic             crc_i,
  input  logic             long_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [31:0]      word_o
);
  always_comb begin
    word_o = '0;
    word_o[CNT_W-1:0] = cnt_i;
    word_o[ST_OWN]  = 1'b1;
    word_o[ST_MORE] = more_i;
    word_o[ST_CRC]  = crc_i;
    word_o[ST_LONG] = long_i;
    word_o[ST_OK]   = !more_i && !crc_i && !long_i;
  end
endmodule

// File: rtl/rx_ring_fsm.sv
`timescale 1ns/1ps
module rx_ring_fsm
  import rx_ring_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_FRAME = 1518
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             clr_ptr_i,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic             ptr_we_i,
  input  logic [AW-1:0]    ptr_wdata_i,
  output logic [AW-1:0]    ring_ptr_o,
  output logic             idle_o,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [7:0]       s_data_i,
  input  logic             s_sof_i,
  input  logic             s_eof_i,
  input  logic             s_err_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [3:0]       mem_be_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             wb_more_o,
  output logic             wb_crc_o,
  output logic             wb_long_o,
  output logic [CNT_W-1:0] wb_cnt_o,
  input  logic [31:0]      wb_word_i
);
  localparam logic [AW-1:0] ALIGN = ~AW'(7);
  localparam logic [AW-1:0] OFS_BUF = AW'(4);
  localparam logic [AW-1:0] OFS_STS = AW'(8);

  walk_state_e st_q;
  logic [AW-1:0]    desc_q, link_q, buf_q, byte_addr;
  logic [CNT_W-1:0] size_q, cnt_q;
  logic [LEN_W-1:0] flen_q;
  logic [7:0]       byte_q;
  logic in_frame_q, eof_q, err_q, stop_q, cnt_full;

  assign byte_addr = buf_q + AW'(cnt_q);
  assign cnt_full  = (cnt_q + CNT_W'(1)) == size_q;
  assign s_ready_o = (st_q == S_RECV) && !(stop_q && !in_frame_q);
  assign idle_o    = (st_q == S_IDLE);
  assign ring_ptr_o = desc_q;

  assign wb_more_o = !eof_q;
  assign wb_crc_o  = eof_q && err_q;
  assign wb_long_o = eof_q && (flen_q > LEN_W'(MAX_FRAME));
  assign wb_cnt_o  = cnt_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      S_RD_STS:  begin mem_req_o = 1'b1; mem_addr_o = desc_q + OFS_STS; end
      S_RD_LINK: begin mem_req_o = 1'b1; mem_addr_o = desc_q; end
      S_RD_BUF:  begin mem_req_o = 1'b1; mem_addr_o = desc_q + OFS_BUF; end
      S_WR_BYTE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {byte_addr[AW-1:2], 2'b00};
        mem_be_o    = 4'b0001 << byte_addr[1:0];
        mem_wdata_o = {4{byte_q}};
      end
      S_WB_STS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q + OFS_STS;
        mem_be_o    = 4'hF;
        mem_wdata_o = wb_word_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      desc_q <= '0; link_q <= '0; buf_q <= '0;
      size_q <= '0; cnt_q <= '0; flen_q <= '0; byte_q <= '0;
      in_frame_q <= 1'b0; eof_q <= 1'b0; err_q <= 1'b0; stop_q <= 1'b0;
    end else if (flush_i) begin
      st_q <= S_IDLE;
      cnt_q <= '0; flen_q <= '0;
      in_frame_q <= 1'b0; eof_q <= 1'b0; err_q <= 1'b0; stop_q <= 1'b0;
      if (clr_ptr_i) desc_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          stop_q <= 1'b0;
          if (ptr_we_i) desc_q <= ptr_wdata_i & ALIGN;
          if (go_i) st_q <= S_RD_STS;
        end
        S_RD_STS: if (mem_ack_i) begin
          if (mem_rdata_i[ST_OWN]) begin
            // host still holds it: park here, drop any open frame
            st_q <= S_IDLE;
            in_frame_q <= 1'b0; flen_q <= '0; err_q <= 1'b0; eof_q <= 1'b0;
          end else begin
            size_q <= mem_rdata_i[CNT_W-1:0];
            st_q <= S_RD_LINK;
          end
        end
        S_RD_LINK: if (mem_ack_i) begin
          link_q <= mem_rdata_i & ALIGN;
          st_q <= S_RD_BUF;
        end
        S_RD_BUF: if (mem_ack_i) begin
          buf_q <= mem_rdata_i & ALIGN;
          cnt_q <= '0;
          st_q <= S_RECV;
        end
        S_RECV: begin
          if (stop_q && !in_frame_q) begin
            st_q <= S_IDLE;
            stop_q <= 1'b0;
          end else if (s_valid_i && (in_frame_q || s_sof_i)) begin
            byte_q <= s_data_i;
            eof_q  <= s_eof_i;
            err_q  <= err_q | (s_eof_i & s_err_i);
            in_frame_q <= 1'b1;
            st_q <= S_WR_BYTE;
          end
        end
        S_WR_BYTE: if (mem_ack_i) begin
          cnt_q  <= cnt_q + CNT_W'(1);
          flen_q <= flen_q + LEN_W'(1);
          st_q   <= (eof_q || cnt_full) ? S_WB_STS : S_RECV;
        end
        S_WB_STS: if (mem_ack_i) begin
          desc_q <= link_q;
          if (eof_q) begin
            in_frame_q <= 1'b0; eof_q <= 1'b0; err_q <= 1'b0; flen_q <= '0;
            st_q <= stop_q ? S_IDLE : S_RD_STS;
          end else begin
            st_q <= S_RD_STS;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (halt_i && st_q != S_IDLE) stop_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_ring_engine.sv
`timescale 1ns/1ps
module rx_ring_engine
  import rx_ring_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MAX_FRAME = 1518
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  output logic [CMD_W-1:0] cmd_rdata_o,
  input  logic             ptr_we_i,
  input  logic [AW-1:0]    ptr_wdata_i,
  output logic [AW-1:0]    ring_ptr_o,
  output logic             idle_o,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [7:0]       s_data_i,
  input  logic             s_sof_i,
  input  logic             s_eof_i,
  input  logic             s_err_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [3:0]       mem_be_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [31:0]      mem_rdata_i
);
  logic flush, clr_ptr, go, halt, bus_free;
  logic wb_more, wb_crc, wb_long;
  logic [CNT_W-1:0] wb_cnt;
  logic [31:0] wb_word;

  assign bus_free = !mem_req_o || mem_ack_i;

  rx_ring_cmd u_cmd (
    .clk_i, .rst_ni, .cmd_we_i, .cmd_wdata_i,
    .bus_free_i(bus_free), .cmd_rdata_o,
    .flush_o(flush), .clr_ptr_o(clr_ptr), .go_o(go), .halt_o(halt)
  );

  rx_ring_stsword #(.CNT_W(CNT_W)) u_sts (
    .more_i(wb_more), .crc_i(wb_crc), .long_i(wb_long),
    .cnt_i(wb_cnt), .word_o(wb_word)
  );

  rx_ring_fsm #(.AW(AW), .CNT_W(CNT_W), .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_fsm (
    .clk_i, .rst_ni,
    .flush_i(flush), .clr_ptr_i(clr_ptr), .go_i(go), .halt_i(halt),
    .ptr_we_i, .ptr_wdata_i, .ring_ptr_o, .idle_o,
    .s_valid_i, .s_ready_o, .s_data_i, .s_sof_i, .s_eof_i, .s_err_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i,
    .wb_more_o(wb_more), .wb_crc_o(wb_crc), .wb_long_o(wb_long),
    .wb_cnt_o(wb_cnt), .wb_word_i(wb_word)
  );
endmodule

// File: rtl/rx_ring_engine_chk.sv
`timescale 1ns/1ps
module rx_ring_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        idle_o,
  input logic        s_ready_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [3:0]  mem_be_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i
);
  a_r13_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r13_word_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  a_r5_wb_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_be_o == 4'hF |-> mem_wdata_o[31]);

  a_r6_more_not_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_be_o == 4'hF && mem_wdata_o[30] |-> !mem_wdata_o[27]);

  a_r4_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_be_o != 4'hF |->
      $countones(mem_be_o) == 1 && mem_wdata_o[7:0] == mem_wdata_o[31:24]);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mem_req_o && !s_ready_o);
endmodule

bind rx_ring_engine rx_ring_engine_chk u_chk (.*);

// File: tb/rx_ring_engine_test.sv
`timescale 1ns/1ps
module rx_ring_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_we = 0, ptr_we = 0;
  logic [8:0]  cmd_wdata = 0, cmd_rdata;
  logic [31:0] ptr_wdata = 0, ring_ptr;
  logic        idle, s_ready;
  logic        s_valid = 0, s_sof = 0, s_eof = 0, s_err = 0;
  logic [7:0]  s_data = 0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [31:0] mem [0:4095];

  int n_chk = 0, n_bad = 0;
  int hidx = 0;
  int gsize = 64;

  rx_ring_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata), .cmd_rdata_o(cmd_rdata),
    .ptr_we_i(ptr_we), .ptr_wdata_i(ptr_wdata), .ring_ptr_o(ring_ptr), .idle_o(idle),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .s_sof_i(s_sof), .s_eof_i(s_eof), .s_err_i(s_err),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[mem_addr[13:2]];
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[13:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // stimulus: {error flag, frame length}, buffer size 64
  localparam int NV = 7;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {1'b0, 16'd20}, {1'b0, 16'd64}, {1'b0, 16'd65}, {1'b0, 16'd150},
    {1'b1, 16'd30}, {1'b0, 16'd4},  {1'b0, 16'd129}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic cmd(input logic [8:0] v);
    @(negedge clk); cmd_we = 1; cmd_wdata = v;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic ptr_write(input logic [31:0] v);
    @(negedge clk); ptr_we = 1; ptr_wdata = v;
    @(negedge clk); ptr_we = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic sof, input logic eof, input logic err);
    @(negedge clk);
    s_valid = 1; s_data = d; s_sof = sof; s_eof = eof; s_err = err;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
  endtask

  function automatic logic [7:0] pat(input int fid, input int i);
    return 8'((fid * 13 + i) & 255);
  endfunction

  function automatic logic [31:0] exp_sts(input int len, input bit err, input int p, input int k);
    logic [31:0] s;
    bit lg;
    if (p < k - 1) return 32'hC000_0000 | 32'(gsize);
    lg = len > 1518;
    s = 32'h8000_0000 | 32'(len - (k - 1) * gsize);
    if (err) s[19] = 1'b1;
    if (lg) s[22] = 1'b1;
    if (!err && !lg) s[27] = 1'b1;
    return s;
  endfunction

  task automatic init_ring(input int size);
    for (int i = 0; i < 4; i++) begin
      mem[i*4]   = 32'(((i + 1) % 4) * 16);
      mem[i*4+1] = 32'(32'h1000 + i * 32'h800);
      mem[i*4+2] = 32'(size);
      mem[i*4+3] = 32'hDEAD_BEEF;
    end
    hidx = 0;
    gsize = size;
  endtask

  task automatic run_frame(input int len, input bit err, input int fid);
    int k, last, d, base, off, cnt;
    bit ok, data_ok;
    k = (len + gsize - 1) / gsize;
    for (int i = 0; i < len; i++)
      send_byte(pat(fid, i), i == 0, i == len - 1, err);
    @(negedge clk); s_valid = 0; s_sof = 0; s_eof = 0; s_err = 0;
    last = (hidx + k - 1) % 4;
    ok = 0;
    for (int t = 0; t < 20000 && !ok; t++) begin
      if (mem[last*4+2][31]) ok = 1;
      else @(negedge clk);
    end
    repeat (4) @(negedge clk);
    for (int p = 0; p < k; p++) begin
      d = (hidx + p) % 4;
      if (p < k - 1) check(mem[d*4+2] == exp_sts(len, err, p, k), "R6 split status", mem[d*4+2], exp_sts(len, err, p, k));
      else check(mem[d*4+2] == exp_sts(len, err, p, k), "R5 final status", mem[d*4+2], exp_sts(len, err, p, k));
      base = 32'h1000 + d * 32'h800;
      cnt = (p < k - 1) ? gsize : len - (k - 1) * gsize;
      data_ok = 1;
      for (int i = 0; i < cnt; i++) begin
        off = base + i;
        if (8'(mem[off >> 2] >> (8 * (off & 3))) != pat(fid, p * gsize + i)) data_ok = 0;
      end
      check(data_ok, "R4 buffer bytes", 32'(d), 32'(fid));
    end
    hidx = (hidx + k) % 4;
    check(ring_ptr == 32'(hidx * 16), "R8 link followed", ring_ptr, 32'(hidx * 16));
    for (int p = 0; p < k; p++) mem[((hidx + 4 - k + p) % 4) * 4 + 2] = 32'(gsize);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(idle == 1 && s_ready == 0, "R1 idle after reset", {idle, s_ready}, 2'b10);
    check(ring_ptr == 0 && cmd_rdata == 0, "R1 pointer and command", ring_ptr | 32'(cmd_rdata), 0);

    init_ring(64);
    ptr_write(32'h17);
    @(negedge clk);
    check(ring_ptr == 32'h10, "R2 pointer masked", ring_ptr, 32'h10);
    ptr_write(32'h0);
    cmd(9'h004);

    for (int v = 0; v < NV; v++)
      run_frame(int'(VEC[v][15:0]), VEC[v][16], v);

    check(mem[3] == 32'hDEAD_BEEF && mem[15] == 32'hDEAD_BEEF && mem[0] == 32'h10 && mem[5] == 32'h1800,
          "R3 other words untouched", mem[3], 32'hDEAD_BEEF);

    // R12: stray bytes before the start flag are dropped
    for (int i = 0; i < 3; i++) send_byte(8'hEE, 0, 0, 0);
    run_frame(10, 0, 20);

    // R9: park on a host-owned descriptor
    mem[((hidx + 1) % 4) * 4 + 2] = 32'h8000_0ABC;
    run_frame(10, 0, 21);
    repeat (10) @(negedge clk);
    check(idle == 1, "R9 idle on owned", idle, 1);
    check(ring_ptr == 32'(hidx * 16), "R9 pointer held", ring_ptr, 32'(hidx * 16));
    check(mem[hidx*4+2] == 32'h8000_0ABC, "R9 descriptor untouched", mem[hidx*4+2], 32'h8000_0ABC);
    mem[hidx*4+2] = 32'(gsize);
    cmd(9'h004);
    run_frame(12, 0, 22);

    // R2: pointer write ignored while running
    ptr_write(32'h200);
    @(negedge clk);
    check(ring_ptr == 32'(hidx * 16), "R2 write ignored running", ring_ptr, 32'(hidx * 16));

    // R10: stop request during a frame
    fork
      run_frame(40, 0, 23);
      begin repeat (40) @(posedge clk); cmd(9'h008); end
    join
    repeat (5) @(negedge clk);
    check(idle == 1 && s_ready == 0, "R10 idle after frame", {idle, s_ready}, 2'b10);
    check(ring_ptr == 32'(hidx * 16), "R10 pointer after stop", ring_ptr, 32'(hidx * 16));
    cmd(9'h004);
    repeat (10) @(negedge clk);
    check(idle == 0, "R3 receive on restarts", idle, 0);

    // R11: chip reset
    @(negedge clk); cmd_we = 1; cmd_wdata = 9'h100;
    @(negedge clk); cmd_we = 0;
    check(cmd_rdata == 9'h100, "R11 reset pending", 32'(cmd_rdata), 32'h100);
    repeat (3) @(negedge clk);
    check(cmd_rdata == 0 && idle == 1 && ring_ptr == 0, "R11 chip reset done", ring_ptr | 32'(cmd_rdata), 0);

    // R11: receive reset keeps pointer
    ptr_write(32'h10);
    cmd(9'h004);
    repeat (20) @(negedge clk);
    cmd(9'h020);
    repeat (3) @(negedge clk);
    check(cmd_rdata == 0 && idle == 1 && ring_ptr == 32'h10, "R11 rx reset keeps pointer", ring_ptr, 32'h10);

    // R7: overlong limit
    cmd(9'h100);
    repeat (3) @(negedge clk);
    init_ring(1536);
    cmd(9'h004);
    run_frame(1518, 0, 31);
    run_frame(1519, 0, 32);

    summary();
    $finish;
  end
endmodule